// File: doc/BRIEF.md
# Shared Data-Ready Serial Output Port

This block drives one output pin that does two jobs in every conversion cycle. First it flags that a fresh result is available, then it hands that result out one bit at a time to an external master. When the upstream filter offers a new word, the port sequences through fixed windows. Each window is a programmable number of system clock cycles, and the pin is high, low or high in turn. At the end of the last window the pin starts carrying the word, most significant bit first.

The master shifts the data with its own serial clock, which is not related to the system clock. That clock is brought into the system domain through a synchroniser, and only its falling edges advance the output. If the master clocks too few bits, the last bit driven stays on the pin. If it clocks too many, the pin goes low. The bit position is re-armed whenever a new announcement begins, so the first bit after every announcement is the MSB of the new word.

Top module: `drdy_serial_port`

## Requirements
- R1: While `rst` is high, and in the idle phase after reset before any word is offered, `pin_o` is high.
- R2: A `word_valid` pulse accepted in idle starts the announcement in the next cycle. `pin_o` is high for `T1_CYC` cycles, then low for `T2_CYC` cycles, then high for `T3_CYC` cycles.
- R3: After the announcement, the port is in the data phase. With no serial clock, `pin_o` shows bit 23 (the MSB, which is set for a negative result) of the accepted word and keeps it for as long as no falling edge arrives.
- R4: In the data phase, each falling edge of `sclk` moves `pin_o` to the next lower bit of the word, 23 down to 0. The change appears within three system clock cycles. Rising edges of `sclk` leave `pin_o` unchanged.
- R5: If fewer than 24 falling edges arrive, `pin_o` holds the last bit driven until the next announcement begins.
- R6: After the 24th falling edge, `pin_o` is low, and further falling edges keep it low.
- R7: A `word_valid` pulse during the data phase ends that phase. `pin_o` is high for `T4_CYC` cycles, then the R2 sequence follows, and the new word's data phase starts at its MSB.
- R8: A `word_valid` pulse while any timed window is running is ignored. It changes neither the window timing nor the word that is later shifted out.
- R9: Falling edges of `sclk` outside the data phase do not move the bit position, so the first bit shown in the data phase is always the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | One-cycle strobe: a new result is on `word_in` |
| word_in | input | WORD_W | Conversion result from the filter |
| sclk | input | 1 | Serial clock from the master, asynchronous |
| pin_o | output | 1 | Shared ready / serial data pin |

## Verification
The bench checks the pin in every cycle of each announcement, so a window that is one cycle too long or too short shows up as a miscompare at its edge. Several frames are under-clocked or over-clocked. A port that wrapped the bit position, or shifted in ones, would show a stale or high bit where the pin should hold or go low. The serial clock is toggled during the windows and a second strobe is injected inside a window. A port that advanced the pointer early would start a frame mid-word, and one that accepted the strobe would restart the windows or emit the wrong word. Every rising edge is checked for no change, which catches a port that shifts on the wrong edge.

// File: rtl/drdy_port_pkg.sv
package drdy_port_pkg;

    // Phases of one conversion cycle on the shared pin.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,   // after reset, nothing offered yet
        PH_HOLD = 3'd1,   // closing window after a data phase (T4)
        PH_PRE  = 3'd2,   // pin high before the word transfer (T1)
        PH_LOW  = 3'd3,   // ready pulse low part (T2)
        PH_MARK = 3'd4,   // ready pulse high part (T3)
        PH_DATA = 3'd5    // master shifts bits out
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   load;     // transfer staged word into the shifter
        logic   rearm;    // bit pointer back to the MSB
    } port_ctl_t;

    function automatic phase_e follow_phase(input phase_e p);
        case (p)
            PH_HOLD: return PH_PRE;
            PH_PRE:  return PH_LOW;
            PH_LOW:  return PH_MARK;
            PH_MARK: return PH_DATA;
            default: return p;
        endcase
    endfunction

    function automatic int unsigned phase_len(input phase_e p,
                                              input int unsigned l1,
                                              input int unsigned l2,
                                              input int unsigned l3,
                                              input int unsigned l4);
        case (p)
            PH_HOLD: return l4;
            PH_PRE:  return l1;
            PH_LOW:  return l2;
            PH_MARK: return l3;
            default: return 1;
        endcase
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic bit is_timed(input phase_e p);
        return (p == PH_HOLD) || (p == PH_PRE) || (p == PH_LOW) || (p == PH_MARK);
    endfunction

endpackage

// File: rtl/drdy_sclk_sync.sv
module drdy_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_async,
    output logic fall_o
);
    // STAGES flops of synchronisation plus one for edge history.
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], sclk_async};
        end
    end

    assign fall_o = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/drdy_phase_fsm.sv
module drdy_phase_fsm
    import drdy_port_pkg::*;
#(
    parameter int T1_CYC = 6,
    parameter int T2_CYC = 4,
    parameter int T3_CYC = 4,
    parameter int T4_CYC = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      word_valid,
    output logic      accept_o,
    output port_ctl_t ctl_o
);
    localparam int unsigned MAXL = max4(T1_CYC, T2_CYC, T3_CYC, T4_CYC);
    localparam int TW = (MAXL > 1) ? $clog2(MAXL) : 1;

    phase_e          phase, nxt;
    logic [TW-1:0]   timer;
    logic            changed;

    always_comb begin
        nxt = phase;
        case (phase)
            PH_IDLE: if (word_valid) nxt = PH_PRE;
            PH_DATA: if (word_valid) nxt = PH_HOLD;
            default: if (timer == '0) nxt = follow_phase(phase);
        endcase
        changed = (nxt != phase);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            timer <= '0;
        end else begin
            phase <= nxt;
            if (changed) begin
                timer <= TW'(phase_len(nxt, T1_CYC, T2_CYC, T3_CYC, T4_CYC) - 1);
            end else if (timer != '0) begin
                timer <= timer - TW'(1);
            end
        end
    end

    assign accept_o    = word_valid && !is_timed(phase);
    assign ctl_o.phase = phase;
    assign ctl_o.load  = (phase == PH_PRE) && (nxt == PH_LOW);
    assign ctl_o.rearm = changed && ((nxt == PH_PRE) || (nxt == PH_HOLD));
endmodule

// File: rtl/drdy_word_path.sv
module drdy_word_path
    import drdy_port_pkg::*;
#(
    parameter int W  = 24,
    parameter int PW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [W-1:0]  word_in,
    input  port_ctl_t     ctl,
    input  logic          fall,
    output logic [PW-1:0] ptr_o,
    output logic          pin_o
);
    localparam logic [PW-1:0] LAST = PW'(W);

    logic [W-1:0]  staged;
    logic [W-1:0]  shifter;
    logic [PW-1:0] ptr;
    logic          over;
    logic          in_data;

    assign in_data = (ctl.phase == PH_DATA);
    assign over    = (ptr == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            staged  <= '0;
            shifter <= '0;
            ptr     <= '0;
        end else begin
            if (accept) staged <= word_in;
            if (ctl.load) shifter <= staged;
            if (ctl.rearm) begin
                ptr <= '0;
            end else if (in_data && fall && !over) begin
                ptr     <= ptr + PW'(1);
                shifter <= {shifter[W-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        if (in_data) pin_o = over ? 1'b0 : shifter[W-1];
        else         pin_o = (ctl.phase != PH_LOW);
    end

    assign ptr_o = ptr;
endmodule

// File: rtl/drdy_serial_port.sv
module drdy_serial_port
    import drdy_port_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int T1_CYC      = 6,
    parameter int T2_CYC      = 4,
    parameter int T3_CYC      = 4,
    parameter int T4_CYC      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    input  logic              sclk,
    output logic              pin_o
);
    localparam int PW = $clog2(WORD_W + 1);

    port_ctl_t     ctl;
    logic          accept;
    logic          sclk_fall;
    logic [PW-1:0] ptr;

    drdy_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sclk_async(sclk), .fall_o(sclk_fall)
    );

    drdy_phase_fsm #(
        .T1_CYC(T1_CYC), .T2_CYC(T2_CYC), .T3_CYC(T3_CYC), .T4_CYC(T4_CYC)
    ) u_fsm (
        .clk(clk), .rst(rst), .word_valid(word_valid),
        .accept_o(accept), .ctl_o(ctl)
    );

    drdy_word_path #(.W(WORD_W), .PW(PW)) u_path (
        .clk(clk), .rst(rst), .accept(accept), .word_in(word_in),
        .ctl(ctl), .fall(sclk_fall), .ptr_o(ptr), .pin_o(pin_o)
    );
endmodule

// File: rtl/drdy_port_chk.sv
module drdy_port_chk
    import drdy_port_pkg::*;
#(
    parameter int W  = 24,
    parameter int PW = $clog2(W + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          pin,
    input phase_e        phase,
    input logic [PW-1:0] ptr,
    input logic          fall,
    input logic          word_valid
);
    a_r1_reset_pin_high: assert property (@(posedge clk) rst |=> pin);

    a_r2_low_only_pulse_or_data: assert property (@(posedge clk) disable iff (rst)
        !pin |-> (phase == PH_LOW || phase == PH_DATA));

    a_r4_step_one_bit: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && fall && !word_valid && ptr != PW'(W))
        |=> ptr == $past(ptr) + PW'(1));

    a_r5_hold_without_fall: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && !fall && !word_valid) |=> ($stable(ptr) && $stable(pin)));

    a_r6_over_pin_low: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && ptr == PW'(W)) |-> !pin);

    a_r7_data_exit_hold: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && word_valid) |=> phase == PH_HOLD);

    a_r8_pulse_not_restarted: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOW && word_valid) |=> (phase == PH_LOW || phase == PH_MARK));

    a_r9_ptr_armed_outside_data: assert property (@(posedge clk) disable iff (rst)
        phase != PH_DATA |-> ptr == '0);
endmodule

bind drdy_serial_port drdy_port_chk #(.W(WORD_W), .PW(PW)) u_chk (
    .clk(clk), .rst(rst), .pin(pin_o), .phase(ctl.phase), .ptr(ptr),
    .fall(sclk_fall), .word_valid(word_valid)
);

// File: tb/sim_drdy_serial_port.sv
module sim_drdy_serial_port;
    localparam int T1 = 6;
    localparam int T2 = 4;
    localparam int T3 = 4;
    localparam int T4 = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_valid = 1'b0;
    logic [23:0] word_in = '0;
    logic        sclk = 1'b0;
    logic        pin_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    drdy_serial_port u0 (
        .clk(clk), .rst(rst), .word_valid(word_valid), .word_in(word_in),
        .sclk(sclk), .pin_o(pin_o)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: pin_o=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic bit_at(input logic [23:0] w, input int k);
        return (k < 24) ? w[23 - k] : 1'b0;
    endfunction

    // Offer a word, then check every cycle of the announcement (R2, R7, R8, R9).
    task automatic frame(input logic [23:0] w, input bit from_data,
                         input bit noisy, input bit extra);
        int pre;
        int total;
        pre   = from_data ? T4 : 0;
        total = pre + T1 + T2 + T3;
        @(negedge clk);
        word_valid = 1'b1;
        word_in    = w;
        @(negedge clk);
        word_valid = 1'b0;
        word_in    = ~w;
        for (int off = 0; off < total; off++) begin
            logic e;
            e = !((off >= pre + T1) && (off < pre + T1 + T2));
            chk(from_data ? "R7 window" : "R2 window", pin_o, e);
            if (noisy) sclk = (off < pre + T1 + T2) ? off[1] : 1'b0;
            if (extra) word_valid = (off == 2) || (off == pre + T1 + 1);
            @(negedge clk);
        end
        word_valid = 1'b0;
        chk(extra ? "R8 first bit" : (noisy ? "R9 first bit MSB" : "R3 MSB"),
            pin_o, w[23]);
        repeat (6) @(negedge clk);
        chk("R3 MSB held", pin_o, w[23]);
    endtask

    // Clock n bits; k0 = falling edges already applied in this frame.
    task automatic clock_bits(input logic [23:0] w, input int k0, input int n);
        for (int i = 0; i < n; i++) begin
            int k;
            k = k0 + i;
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            chk("R4 rise no change", pin_o, bit_at(w, k));
            sclk = 1'b0;
            repeat (4) @(negedge clk);
            chk((k + 1 >= 24) ? "R6 over-clock" : "R4 next bit", pin_o, bit_at(w, k + 1));
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 in reset", pin_o, 1'b1);
        rst = 1'b0;
        for (int i = 0; i < 12; i++) begin
            sclk = i[1];
            @(negedge clk);
            chk("R1 idle", pin_o, 1'b1);
        end
        sclk = 1'b0;
        repeat (4) @(negedge clk);

        frame(24'hA5C396, 0, 1, 0);
        clock_bits(24'hA5C396, 0, 24);

        frame(24'h800001, 1, 0, 1);
        clock_bits(24'h800001, 0, 10);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (i % 5 == 0) chk("R5 under-clock hold", pin_o, bit_at(24'h800001, 10));
        end

        frame(24'hFFFFFF, 1, 0, 0);
        clock_bits(24'hFFFFFF, 0, 30);
        repeat (10) @(negedge clk);
        chk("R6 stays low", pin_o, 1'b0);

        frame(24'h000000, 1, 1, 1);
        clock_bits(24'h000000, 0, 24);

        frame(24'h7FFFFE, 1, 1, 0);
        clock_bits(24'h7FFFFE, 0, 24);

        for (int s = 1; s <= 4; s++) begin
            logic [31:0] h;
            h = 32'h9E3779B9 * s;
            frame(h[27:4], 1, s[0], s[1]);
            clock_bits(h[27:4], 0, 20 + s * 2);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (R1..R9 run incomplete): got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule